// File: doc/BRIEF.md
# UART Host Register and Interrupt Unit

This block is the processor-facing half of an asynchronous serial port. It decodes bus accesses made through two chip selects, two register-select lines, a read/write line and a bus strobe. It keeps the command and control bytes and hands a written transmit byte to the transmitter. It holds the last received byte together with its error flags, and it builds the status byte. It also drives an active-low interrupt request and the modem handshake outputs.

The carrier-detect and data-set-ready inputs are watched for level changes. A change raises an interrupt and freezes the reported level. The frozen level holds until software reads the status byte. The read re-arms the watcher, and a level that moved during the freeze raises a fresh interrupt at once.

Two resets are supported. The asynchronous hardware reset brings every register to its initial state. A program reset is a bus write that clears only part of the state.

Register select values (rsel[1:0]):
- 00: write sends a transmit byte; read returns the receive byte.
- 01: write performs a program reset; read returns the status byte.
- 10: the command byte.
- 11: the control byte.

Top module: `sio_host_regs`

## Requirements
- R1: An access happens only on a falling edge of `bus_stb` while `cs_hi` is 1 and `cs_n` is 0. With either select inactive, a write changes nothing and a read returns 0x00.
- R2: The command byte is written and read at rsel 10, and the control byte at rsel 11. Each reads back exactly what was last written.
- R3: After hardware reset the command and control bytes are 0x00, `irq_n` and `dtr_n` are 1, and the status byte is 0x10 with bits 6 and 5 equal to the `dsr_n` and `dcd_n` levels. With both inputs high, the status byte reads 0x70.
- R4: The status byte is laid out as bit 7 interrupt, bit 6 DSR level, bit 5 DCD level, bit 4 transmit empty, bit 3 receive full, bit 2 overrun, bit 1 framing error and bit 0 parity error. A write at rsel 00 clears bit 4. In the cycle after that write, `tx_load` pulses for one cycle with the written byte on `tx_data`. A `tx_taken` pulse sets bit 4.
- R5: When `rx_strobe` pulses with the receive register empty, the block stores `rx_byte`, sets bit 3 and copies `rx_par_err` and `rx_frm_err` into bits 0 and 1. Reading at rsel 00 returns the stored byte and clears bits 3, 2, 1 and 0.
- R6: When `rx_strobe` pulses while bit 3 is already set, the stored byte is kept unchanged and bit 2 (overrun) is set.
- R7: Reading the status byte clears bit 7, and `irq_n` returns to 1 unless a new interrupt condition arrives in that same cycle. `irq_n` is always the inverse of status bit 7.
- R8: A stored receive byte raises an interrupt only when command bit 1 is 0 and command bit 0 is 1. A `tx_taken` pulse raises one only when command bits 3:2 are 01 and command bit 0 is 1.
- R9: `dtr_n` is the inverse of command bit 0. `rts_n` is 1 when command bits 3:2 are 00 and 0 otherwise. While command bit 0 is 0, no new interrupt of any kind is raised, DCD and DSR included, and status bits 6:5 simply track the inputs.
- R10: With command bit 0 set, a change on `dcd_n` or `dsr_n` raises an interrupt and latches the new levels into status bits 6:5. Those bits do not move again until the status byte is read.
- R11: If a DCD or DSR level differs from its latched value when the status byte is read, a new interrupt is raised right after the read, and the bit shows the new level.
- R12: A write at rsel 01 clears command bits 4:0, the overrun bit and any pending DCD/DSR interrupt. It leaves the control byte unchanged, and it leaves a pending transmit or receive interrupt asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cs_hi | input | 1 | Active-high chip select |
| cs_n | input | 1 | Active-low chip select |
| rsel | input | 2 | Register select |
| rd_wr | input | 1 | 1 = read, 0 = write |
| bus_stb | input | 1 | Bus strobe; an access takes effect on its falling edge |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data to the processor |
| irq_n | output | 1 | Active-low interrupt request |
| tx_data | output | 8 | Byte for the transmitter |
| tx_load | output | 1 | One-cycle pulse: new byte on tx_data |
| tx_taken | input | 1 | Transmitter has moved the byte into its shifter |
| rx_byte | input | 8 | Byte assembled by the receiver |
| rx_strobe | input | 1 | Receiver has a complete byte |
| rx_par_err | input | 1 | Parity error for rx_byte |
| rx_frm_err | input | 1 | Framing error for rx_byte |
| dcd_n | input | 1 | Carrier detect from the modem, active low |
| dsr_n | input | 1 | Data set ready from the modem, active low |
| dtr_n | output | 1 | Data terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| cmd_o | output | 8 | Current command byte for the serial engines |
| ctl_o | output | 8 | Current control byte for the serial engines |

## Verification
The bench targets the freeze of the DCD/DSR levels. A level that moves while an interrupt is pending must stay hidden until the status read, and then it must raise a second interrupt. A design that followed the input freely would show the wrong level, and one that compared against a running copy would miss the second interrupt.

The bench also checks that a program reset clears command bits 4:0, overrun and a pending modem interrupt while keeping the control byte and a pending transmit interrupt. A design that treated it like a hardware reset would lose both of those. Further checks cover:
- an overrun, where the stored byte must survive;
- the receive interrupt blocked by command bit 1;
- a DCD edge ignored while command bit 0 is clear.

// File: rtl/sio_regs_pkg.sv
package sio_regs_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 2;
  localparam int NREG   = 1 << SEL_W;

  typedef enum logic [SEL_W-1:0] {
    SEL_DATA = 2'b00,
    SEL_STAT = 2'b01,
    SEL_CMD  = 2'b10,
    SEL_CTL  = 2'b11
  } reg_sel_e;

  typedef struct packed {
    logic irq;
    logic dsr_lvl;
    logic dcd_lvl;
    logic tx_empty;
    logic rx_full;
    logic overrun;
    logic frm_err;
    logic par_err;
  } status_t;
endpackage

// File: rtl/sio_bus_decode.sv
module sio_bus_decode #(
  parameter int SEL_W = 2,
  localparam int NREG = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_i,
  input  logic             bus_stb,
  input  logic             cs_hi,
  input  logic             cs_n,
  input  logic             rd_wr,
  input  logic [SEL_W-1:0] rsel,
  output logic             selected,
  output logic [NREG-1:0]  wr_hit,
  output logic [NREG-1:0]  rd_hit
);
  logic stb_q;
  logic stb_fall;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) stb_q <= 1'b0;
    else        stb_q <= bus_stb;
  end

  assign selected = cs_hi & ~cs_n;
  assign stb_fall = stb_q & ~bus_stb & selected;

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign wr_hit[g] = stb_fall & ~rd_wr & (rsel == SEL_W'(g));
    assign rd_hit[g] = stb_fall &  rd_wr & (rsel == SEL_W'(g));
  end
endmodule

// File: rtl/sio_line_watch.sv
module sio_line_watch #(
  parameter int LINES = 2,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_i,
  input  logic [LINES-1:0] lvl_in,
  input  logic             enable,
  input  logic             ack,
  input  logic             flush,
  output logic [LINES-1:0] level,
  output logic             pending,
  output logic             change
);
  logic [SYNC-1:0][LINES-1:0] sync_q;
  logic [LINES-1:0] ref_q, ref_d;
  logic             pend_q, pend_d;
  logic [LINES-1:0] seen;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC-2:0], lvl_in};
  end

  assign seen   = sync_q[SYNC-1];
  assign change = enable & ~pend_q & (seen != ref_q);

  always_comb begin
    ref_d  = ref_q;
    pend_d = pend_q;
    if (!pend_q) ref_d = seen;
    if (ack || flush) pend_d = 1'b0;
    if (change) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ref_q  <= '1;
      pend_q <= 1'b0;
    end else begin
      ref_q  <= ref_d;
      pend_q <= pend_d;
    end
  end

  assign level   = ref_q;
  assign pending = pend_q;
endmodule

// File: rtl/sio_rx_hold.sv
module sio_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_i,
  input  logic              rx_strobe,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_par_err,
  input  logic              rx_frm_err,
  input  logic              rd_ack,
  input  logic              clr_ovr,
  output logic [DATA_W-1:0] data,
  output logic              full,
  output logic              overrun,
  output logic              par_err,
  output logic              frm_err,
  output logic              loaded
);
  logic [DATA_W-1:0] data_d;
  logic full_d, ovr_d, pe_d, fe_d;
  logic room;

  assign room   = ~full | rd_ack;
  assign loaded = rx_strobe & room;

  always_comb begin
    data_d = data;
    full_d = full;
    ovr_d  = overrun;
    pe_d   = par_err;
    fe_d   = frm_err;
    if (rd_ack) begin
      full_d = 1'b0;
      ovr_d  = 1'b0;
      pe_d   = 1'b0;
      fe_d   = 1'b0;
    end
    if (clr_ovr) ovr_d = 1'b0;
    if (rx_strobe) begin
      if (room) begin
        data_d = rx_byte;
        full_d = 1'b1;
        pe_d   = rx_par_err;
        fe_d   = rx_frm_err;
      end else begin
        ovr_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      data    <= '0;
      full    <= 1'b0;
      overrun <= 1'b0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
    end else begin
      data    <= data_d;
      full    <= full_d;
      overrun <= ovr_d;
      par_err <= pe_d;
      frm_err <= fe_d;
    end
  end
endmodule

// File: rtl/sio_host_regs.sv
module sio_host_regs
  import sio_regs_pkg::*;
#(
  parameter int RST_STAGES = 2,
  parameter int IN_SYNC    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_hi,
  input  logic              cs_n,
  input  logic [SEL_W-1:0]  rsel,
  input  logic              rd_wr,
  input  logic              bus_stb,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              irq_n,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_load,
  input  logic              tx_taken,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_strobe,
  input  logic              rx_par_err,
  input  logic              rx_frm_err,
  input  logic              dcd_n,
  input  logic              dsr_n,
  output logic              dtr_n,
  output logic              rts_n,
  output logic [DATA_W-1:0] cmd_o,
  output logic [DATA_W-1:0] ctl_o
);
  // reset: asserted asynchronously, released on the clock
  logic [RST_STAGES-1:0] rst_pipe;
  logic rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_i = rst_pipe[RST_STAGES-1];

  // bus decode
  logic            selected;
  logic [NREG-1:0] wr_hit, rd_hit;
  logic wr_tdr, wr_prst, wr_cmd, wr_ctl, rd_rdr, rd_stat;

  sio_bus_decode #(.SEL_W(SEL_W)) u_dec (
    .clk(clk), .rst_i(rst_i), .bus_stb(bus_stb), .cs_hi(cs_hi), .cs_n(cs_n),
    .rd_wr(rd_wr), .rsel(rsel), .selected(selected),
    .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  assign wr_tdr  = wr_hit[SEL_DATA];
  assign wr_prst = wr_hit[SEL_STAT];
  assign wr_cmd  = wr_hit[SEL_CMD];
  assign wr_ctl  = wr_hit[SEL_CTL];
  assign rd_rdr  = rd_hit[SEL_DATA];
  assign rd_stat = rd_hit[SEL_STAT];

  // command, control, transmit holding
  logic [DATA_W-1:0] cmd_q, cmd_d, ctl_q, ctl_d, tdr_q, tdr_d;
  logic tx_empty_q, tx_empty_d, tx_load_q;
  logic tx_ie, rx_ie;

  assign tx_ie = cmd_q[0] & (cmd_q[3:2] == 2'b01);
  assign rx_ie = cmd_q[0] & ~cmd_q[1];

  always_comb begin
    cmd_d      = cmd_q;
    ctl_d      = ctl_q;
    tdr_d      = tdr_q;
    tx_empty_d = tx_empty_q;
    if (wr_cmd)  cmd_d = din;
    if (wr_prst) cmd_d[4:0] = '0;
    if (wr_ctl)  ctl_d = din;
    if (tx_taken) tx_empty_d = 1'b1;
    if (wr_tdr) begin
      tdr_d      = din;
      tx_empty_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cmd_q      <= '0;
      ctl_q      <= '0;
      tdr_q      <= '0;
      tx_empty_q <= 1'b1;
      tx_load_q  <= 1'b0;
    end else begin
      cmd_q      <= cmd_d;
      ctl_q      <= ctl_d;
      tdr_q      <= tdr_d;
      tx_empty_q <= tx_empty_d;
      tx_load_q  <= wr_tdr;
    end
  end

  // receive holding
  logic [DATA_W-1:0] rdr;
  logic rx_full, rx_ovr, rx_pe, rx_fe, rx_loaded;

  sio_rx_hold #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_i(rst_i), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rd_ack(rd_rdr),
    .clr_ovr(wr_prst), .data(rdr), .full(rx_full), .overrun(rx_ovr),
    .par_err(rx_pe), .frm_err(rx_fe), .loaded(rx_loaded)
  );

  // modem line watch: index 1 = DSR, index 0 = DCD
  logic [1:0] mdm_lvl;
  logic mdm_pend, mdm_change;

  sio_line_watch #(.LINES(2), .SYNC(IN_SYNC)) u_mdm (
    .clk(clk), .rst_i(rst_i), .lvl_in({dsr_n, dcd_n}), .enable(cmd_q[0]),
    .ack(rd_stat), .flush(wr_prst), .level(mdm_lvl), .pending(mdm_pend),
    .change(mdm_change)
  );

  // interrupt events
  logic tx_evt_q, tx_evt_d, rx_evt_q, rx_evt_d;

  always_comb begin
    tx_evt_d = tx_evt_q;
    rx_evt_d = rx_evt_q;
    if (rd_stat) begin
      tx_evt_d = 1'b0;
      rx_evt_d = 1'b0;
    end
    if (tx_taken && tx_ie)  tx_evt_d = 1'b1;
    if (rx_loaded && rx_ie) rx_evt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      tx_evt_q <= 1'b0;
      rx_evt_q <= 1'b0;
    end else begin
      tx_evt_q <= tx_evt_d;
      rx_evt_q <= rx_evt_d;
    end
  end

  // status and read mux
  status_t stat;
  always_comb begin
    stat.irq      = tx_evt_q | rx_evt_q | mdm_pend;
    stat.dsr_lvl  = mdm_lvl[1];
    stat.dcd_lvl  = mdm_lvl[0];
    stat.tx_empty = tx_empty_q;
    stat.rx_full  = rx_full;
    stat.overrun  = rx_ovr;
    stat.frm_err  = rx_fe;
    stat.par_err  = rx_pe;
  end

  always_comb begin
    dout = '0;
    if (selected && rd_wr) begin
      unique case (reg_sel_e'(rsel))
        SEL_DATA: dout = rdr;
        SEL_STAT: dout = stat;
        SEL_CMD:  dout = cmd_q;
        SEL_CTL:  dout = ctl_q;
      endcase
    end
  end

  assign irq_n   = ~stat.irq;
  assign tx_data = tdr_q;
  assign tx_load = tx_load_q;
  assign dtr_n   = ~cmd_q[0];
  assign rts_n   = (cmd_q[3:2] == 2'b00);
  assign cmd_o   = cmd_q;
  assign ctl_o   = ctl_q;
endmodule

// File: rtl/sio_host_regs_chk.sv
module sio_host_regs_chk (
  input logic       clk,
  input logic       rst_i,
  input logic       wr_tdr,
  input logic       wr_prst,
  input logic       rd_stat,
  input logic       rd_rdr,
  input logic       tx_empty_q,
  input logic       tx_taken,
  input logic       rx_strobe,
  input logic       rx_full,
  input logic       rx_loaded,
  input logic [7:0] rdr,
  input logic       mdm_pend,
  input logic       mdm_change,
  input logic [1:0] mdm_lvl,
  input logic [7:0] cmd_q,
  input logic [7:0] ctl_q,
  input logic       irq_n
);
  // R4: a transmit write leaves the holding register not empty
  assert_tdr_not_empty_R4: assert property (@(posedge clk) disable iff (!rst_i)
    wr_tdr |=> !tx_empty_q);

  // R7: status read with no new event releases the request
  assert_stat_read_release_R7: assert property (@(posedge clk) disable iff (!rst_i)
    (rd_stat && !rx_loaded && !tx_taken && !mdm_change) |=> irq_n);

  // R6: overrun keeps the stored byte
  assert_overrun_keeps_byte_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (rx_strobe && rx_full && !rd_rdr) |=> $stable(rdr));

  // R10: latched modem levels hold while pending
  assert_modem_freeze_R10: assert property (@(posedge clk) disable iff (!rst_i)
    (mdm_pend && !rd_stat && !wr_prst) |=> $stable(mdm_lvl));

  // R12: program reset keeps the control byte
  assert_prst_keeps_ctl_R12: assert property (@(posedge clk) disable iff (!rst_i)
    wr_prst |=> $stable(ctl_q));

  // R9: a new request needs command bit 0 set
  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(irq_n) |-> $past(cmd_q[0]));
endmodule

bind sio_host_regs sio_host_regs_chk u_chk (
  .clk(clk), .rst_i(rst_i), .wr_tdr(wr_tdr), .wr_prst(wr_prst),
  .rd_stat(rd_stat), .rd_rdr(rd_rdr), .tx_empty_q(tx_empty_q),
  .tx_taken(tx_taken), .rx_strobe(rx_strobe), .rx_full(rx_full),
  .rx_loaded(rx_loaded), .rdr(rdr), .mdm_pend(mdm_pend),
  .mdm_change(mdm_change), .mdm_lvl(mdm_lvl), .cmd_q(cmd_q),
  .ctl_q(ctl_q), .irq_n(irq_n)
);

// File: tb/test_sio_host_regs.sv
module test_sio_host_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_hi = 1'b0, cs_n = 1'b1, rd_wr = 1'b1, bus_stb = 1'b0;
  logic [1:0] rsel = 2'b00;
  logic [7:0] din = '0;
  logic [7:0] dout, tx_data, cmd_o, ctl_o;
  logic irq_n, tx_load, dtr_n, rts_n;
  logic tx_taken = 1'b0, rx_strobe = 1'b0, rx_par_err = 1'b0, rx_frm_err = 1'b0;
  logic [7:0] rx_byte = '0;
  logic dcd_n = 1'b1, dsr_n = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sio_host_regs i_sio_host_regs (
    .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .cs_n(cs_n), .rsel(rsel),
    .rd_wr(rd_wr), .bus_stb(bus_stb), .din(din), .dout(dout), .irq_n(irq_n),
    .tx_data(tx_data), .tx_load(tx_load), .tx_taken(tx_taken),
    .rx_byte(rx_byte), .rx_strobe(rx_strobe), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err), .dcd_n(dcd_n), .dsr_n(dsr_n), .dtr_n(dtr_n),
    .rts_n(rts_n), .cmd_o(cmd_o), .ctl_o(ctl_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] sel, input logic [7:0] val, input bit chosen = 1'b1);
    @(negedge clk);
    cs_hi = chosen; cs_n = ~chosen; rsel = sel; rd_wr = 1'b0; din = val; bus_stb = 1'b1;
    @(negedge clk);
    bus_stb = 1'b0;
    @(negedge clk);
    cs_hi = 1'b0; cs_n = 1'b1; rd_wr = 1'b1;
  endtask

  task automatic bus_read(input logic [1:0] sel, output logic [7:0] val, input bit chosen = 1'b1);
    @(negedge clk);
    cs_hi = chosen; cs_n = ~chosen; rsel = sel; rd_wr = 1'b1; bus_stb = 1'b1;
    @(negedge clk);
    val = dout;
    bus_stb = 1'b0;
    @(negedge clk);
    cs_hi = 1'b0; cs_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    bus_read(2'b01, v);      check("R3 status after reset", v, 8'h70);
    bus_read(2'b10, v);      check("R3 command after reset", v, 8'h00);
    bus_read(2'b11, v);      check("R3 control after reset", v, 8'h00);
    check("R3 irq_n after reset", {7'd0, irq_n}, 8'h01);
    check("R3 dtr_n after reset", {7'd0, dtr_n}, 8'h01);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    bus_write(2'b11, 8'hA5);
    bus_read(2'b11, v);      check("R2 control readback", v, 8'hA5);
    bus_write(2'b10, 8'h40);
    bus_read(2'b10, v);      check("R2 command readback", v, 8'h40);
    bus_write(2'b11, 8'h3C, 1'b0);
    bus_read(2'b11, v);      check("R1 deselected write ignored", v, 8'hA5);
    bus_read(2'b11, v, 1'b0); check("R1 deselected read is zero", v, 8'h00);
  endtask

  task automatic t_lines;
    bus_write(2'b10, 8'h09);
    check("R9 dtr_n low with bit0", {7'd0, dtr_n}, 8'h00);
    check("R9 rts_n low with bits 10", {7'd0, rts_n}, 8'h00);
    bus_write(2'b10, 8'h00);
    check("R9 rts_n high with bits 00", {7'd0, rts_n}, 8'h01);
  endtask

  task automatic t_tx;
    logic [7:0] v;
    bus_write(2'b10, 8'h07);     // rx irq off, tx irq on
    bus_write(2'b00, 8'h3C);
    check("R4 tx_load pulse", {7'd0, tx_load}, 8'h01);
    check("R4 tx_data", tx_data, 8'h3C);
    bus_read(2'b01, v);          check("R4 status after tx write", v, 8'h60);
    tx_taken = 1'b1; @(negedge clk); tx_taken = 1'b0;
    check("R8 tx interrupt raised", {7'd0, irq_n}, 8'h00);
    bus_read(2'b01, v);          check("R4 status after taken", v, 8'hF0);
    check("R7 irq released by status read", {7'd0, irq_n}, 8'h01);
    bus_write(2'b10, 8'h0B);     // tx control 10: no tx irq
    tx_taken = 1'b1; @(negedge clk); tx_taken = 1'b0;
    check("R8 tx interrupt disabled", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_rx;
    logic [7:0] v;
    bus_write(2'b10, 8'h01);
    rx_byte = 8'h5A; rx_par_err = 1'b1; rx_strobe = 1'b1;
    @(negedge clk); rx_strobe = 1'b0; rx_par_err = 1'b0;
    check("R8 rx interrupt raised", {7'd0, irq_n}, 8'h00);
    bus_read(2'b01, v);          check("R5 status with byte", v, 8'hF9);
    bus_read(2'b00, v);          check("R5 rx byte", v, 8'h5A);
    bus_read(2'b01, v);          check("R5 status after data read", v, 8'h70);
  endtask

  task automatic t_overrun_prst;
    logic [7:0] v;
    bus_write(2'b10, 8'hE7);     // bit1 = 1 blocks rx irq
    rx_byte = 8'h11; rx_strobe = 1'b1; @(negedge clk); rx_strobe = 1'b0;
    check("R8 rx interrupt blocked by bit1", {7'd0, irq_n}, 8'h01);
    rx_byte = 8'h22; rx_strobe = 1'b1; @(negedge clk); rx_strobe = 1'b0;
    bus_read(2'b01, v);          check("R6 overrun status", v, 8'h7C);
    bus_write(2'b01, 8'h00);
    bus_read(2'b10, v);          check("R12 command after program reset", v, 8'hE0);
    bus_read(2'b11, v);          check("R12 control kept", v, 8'hA5);
    bus_read(2'b01, v);          check("R12 overrun cleared", v, 8'h78);
    bus_read(2'b00, v);          check("R6 first byte kept", v, 8'h11);
  endtask

  task automatic t_modem;
    logic [7:0] v;
    bus_write(2'b10, 8'h03);
    dcd_n = 1'b0; idle(5);
    check("R10 dcd change interrupt", {7'd0, irq_n}, 8'h00);
    dcd_n = 1'b1; idle(5);
    bus_read(2'b01, v);          check("R10 dcd frozen low", v, 8'hD0);
    idle(3);
    check("R11 re-raise after read", {7'd0, irq_n}, 8'h00);
    bus_read(2'b01, v);          check("R11 new dcd level", v, 8'hF0);
    check("R7 irq released", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_prst_pending;
    logic [7:0] v;
    dsr_n = 1'b0; idle(5);
    check("R10 dsr change interrupt", {7'd0, irq_n}, 8'h00);
    bus_write(2'b01, 8'h00);
    idle(3);
    check("R12 modem interrupt cleared", {7'd0, irq_n}, 8'h01);
    bus_write(2'b10, 8'h05);
    bus_write(2'b00, 8'h77);
    tx_taken = 1'b1; @(negedge clk); tx_taken = 1'b0;
    bus_write(2'b01, 8'h00);
    check("R12 tx interrupt kept", {7'd0, irq_n}, 8'h00);
    bus_read(2'b01, v);          check("R12 status with kept irq", v, 8'hB0);
    dcd_n = 1'b0; idle(5);
    check("R9 no modem irq while disabled", {7'd0, irq_n}, 8'h01);
    bus_read(2'b01, v);          check("R9 levels track while disabled", v, 8'h10);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset;
    t_regs;
    t_lines;
    t_tx;
    t_rx;
    t_overrun_prst;
    t_modem;
    t_prst_pending;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule